// File: doc/BRIEF.md
# Flash Chip-Select Register Bank

This block is the register bank of a serial flash controller. A 32-bit bus master reads and writes a 64-word register array through a byte-addressed port. The block drives one active-low chip-select line for each attached flash device. Each line is taken from a "hold deselected" flag in that device's own control word, so software selects or releases a device by writing to its control word.

A static parameter picks one of two register layouts. The multi-device layout serves up to five devices. Their control words follow one another starting at byte 0x10, and segment window words start at byte 0x30. The single-device layout serves one device. Its control word is at byte 0x04. The configuration word at byte 0x00 is shared by both layouts, but the write-enable flag for device 0 sits at bit 16 in the multi-device layout and at bit 0 in the single-device layout. Shifting, command sequencing, memory-mapped flash reads and interrupts belong to neighbouring blocks.

Top module: `sflash_regbank`

## Requirements
- R1: After reset every word reads 0, except that the control word of each configured device reads 0x0000_0004. All chip-select outputs are 1, and read data is 0.
- R2: Chip-select output i equals bit 2 of device i's control word. After a write to that word, the output shows the written bit 2 at the first clock edge after the write edge, which is one cycle after the write.
- R3: A write stores all 32 bits of an in-range word. A read returns that word on `busRdata` one cycle after the request, and `busRdata` holds that value until the next read.
- R4: Device i's control word is at byte 0x10 + 4*i in the multi-device layout (`SINGLE_SLAVE`=0). The only control word is at byte 0x04 in the single-device layout (`SINGLE_SLAVE`=1). In each layout, the word at the other layout's address is plain storage.
- R5: `wrEnSlave0` equals bit 16 of the word at byte 0x00 in the multi-device layout, and bit 0 of that word in the single-device layout.
- R6: The device count is `NUM_CS` clamped to at most 5 (multi-device) or 1 (single-device). Chip-select outputs at or above that count stay 1, even when the word at the matching offset is written.
- R7: A word index (byte address shifted right by 2) of 64 or more reads 0. A write to such an index changes no word and no output; in particular it does not alias onto the low words.
- R8: `userMode[i]` is 1 exactly when the low two bits of configured device i's control word are 3. It is 0 for devices at or above the count.
- R9: A write to a word that is not a configured control word leaves every chip-select output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busValid | input | 1 | Request strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid one cycle after a read request |
| csN | output | 5 | Chip-select lines, 1 = device deselected |
| userMode | output | 5 | Device control word selects user mode |
| wrEnSlave0 | output | 1 | Write-enable flag of device 0 from the configuration word |

## Verification
The bench runs one multi-device instance with three devices configured and one single-device instance asked for four devices, so that clamping is exercised. Both instances see the same bus traffic, so each write lands on a control word in one layout and on plain storage in the other. A write to byte 0x110 targets word 68. A design that dropped the high address bits would alias this write onto word 4 and deselect device 0. Writing the words of unconfigured devices must not move their chip-selects or user-mode flags. Reading 0x00 after setting bit 16 and then bit 0 catches an enable bit taken from the wrong position.

// File: rtl/sflash_regbank_pkg.sv
package sflash_regbank_pkg;
  localparam int REG_WORDS = 64;
  localparam int CS_PORTS  = 5;
  localparam int STOP_BIT  = 2;

  typedef struct packed {
    logic wrStb;    // accepted write
    logic rdStb;    // accepted read
    logic inRange;  // word index inside the array
    logic ctrlWr;   // write lands on a configured control word
  } regStrobe_t;

  function automatic int maxCs(bit single);
    return single ? 1 : 5;
  endfunction

  function automatic int csCount(bit single, int req);
    int m;
    m = maxCs(single);
    if (req > m) return m;
    if (req < 1) return 1;
    return req;
  endfunction

  function automatic int ctrlBase(bit single);
    return single ? 1 : 4;
  endfunction

  function automatic int wenBit(bit single);
    return single ? 0 : 16;
  endfunction
endpackage

// File: rtl/sflash_regbank_ctl.sv
module sflash_regbank_ctl
  import sflash_regbank_pkg::*;
#(
  parameter bit SINGLE_SLAVE = 1'b0,
  parameter int NUM_CS       = 5,
  parameter int ADDR_W       = 12
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-3:0] wordIdx,
  output regStrobe_t        stb
);
  localparam int NCS  = csCount(SINGLE_SLAVE, NUM_CS);
  localparam int BASE = ctrlBase(SINGLE_SLAVE);

  int idx;
  always_comb begin
    idx         = int'(wordIdx);
    stb.inRange = idx < REG_WORDS;
    stb.wrStb   = busValid && busWrite;
    stb.rdStb   = busValid && !busWrite;
    stb.ctrlWr  = stb.wrStb && stb.inRange && (idx >= BASE) && (idx < BASE + NCS);
  end
endmodule

// File: rtl/sflash_regbank_dp.sv
module sflash_regbank_dp
  import sflash_regbank_pkg::*;
#(
  parameter bit SINGLE_SLAVE = 1'b0,
  parameter int NUM_CS       = 5,
  parameter int ADDR_W       = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  regStrobe_t          stb,
  input  logic [ADDR_W-3:0]   wordIdx,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic [CS_PORTS-1:0] csN,
  output logic [CS_PORTS-1:0] userMode,
  output logic                wrEnSlave0
);
  localparam int NCS  = csCount(SINGLE_SLAVE, NUM_CS);
  localparam int BASE = ctrlBase(SINGLE_SLAVE);
  localparam int WEN  = wenBit(SINGLE_SLAVE);
  localparam int IW   = $clog2(REG_WORDS);

  logic [31:0]         regs [REG_WORDS];
  logic [CS_PORTS-1:0] csNext;
  logic [IW-1:0]       slot;

  assign slot = wordIdx[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < REG_WORDS; w++)
        regs[w] <= (w >= BASE && w < BASE + NCS) ? 32'h0000_0004 : 32'h0;
      rdata <= '0;
      csN   <= '1;
    end else begin
      if (stb.wrStb && stb.inRange) regs[slot] <= wdata;
      if (stb.rdStb) rdata <= stb.inRange ? regs[slot] : 32'h0;
      if (stb.ctrlWr) csN <= csNext;
    end
  end

  // every chip-select is recomputed, with the word being written merged in
  for (genvar g = 0; g < CS_PORTS; g++) begin : gCs
    if (g < NCS) begin : gLive
      localparam int W = BASE + g;
      assign csNext[g]   = (stb.wrStb && int'(wordIdx) == W) ? wdata[STOP_BIT]
                                                               : regs[W][STOP_BIT];
      assign userMode[g] = (regs[W][1:0] == 2'b11);
    end else begin : gIdle
      assign csNext[g]   = 1'b1;
      assign userMode[g] = 1'b0;
    end
  end

  assign wrEnSlave0 = regs[0][WEN];
endmodule

// File: rtl/sflash_regbank.sv
module sflash_regbank
  import sflash_regbank_pkg::*;
#(
  parameter bit SINGLE_SLAVE = 1'b0,
  parameter int NUM_CS       = 5,
  parameter int ADDR_W       = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [4:0]        csN,
  output logic [4:0]        userMode,
  output logic              wrEnSlave0
);
  regStrobe_t        stb;
  logic [ADDR_W-3:0] wordIdx;

  assign wordIdx = busAddr[ADDR_W-1:2];

  sflash_regbank_ctl #(.SINGLE_SLAVE(SINGLE_SLAVE), .NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) uCtl (
    .busValid(busValid), .busWrite(busWrite), .wordIdx(wordIdx), .stb(stb)
  );

  sflash_regbank_dp #(.SINGLE_SLAVE(SINGLE_SLAVE), .NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rst(rst), .stb(stb), .wordIdx(wordIdx), .wdata(busWdata),
    .rdata(busRdata), .csN(csN), .userMode(userMode), .wrEnSlave0(wrEnSlave0)
  );
endmodule

// File: rtl/sflash_regbank_chk.sv
module sflash_regbank_chk
  import sflash_regbank_pkg::*;
#(
  parameter bit SINGLE_SLAVE = 1'b0,
  parameter int NUM_CS       = 5,
  parameter int ADDR_W       = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [4:0]        csN,
  input logic [4:0]        userMode
);
  localparam int NCS  = csCount(SINGLE_SLAVE, NUM_CS);
  localparam int BASE = ctrlBase(SINGLE_SLAVE);
  localparam logic [4:0] LIVE = 5'((32'd1 << NCS) - 1);

  int  wIdx;
  logic ctrlHit;
  logic prevRst;
  assign wIdx    = int'(busAddr[ADDR_W-1:2]);
  assign ctrlHit = (wIdx >= BASE) && (wIdx < BASE + NCS);

  always_ff @(posedge clk) prevRst <= rst;

  // R1
  always_ff @(posedge clk)
    if (prevRst && !rst) reset_cs_idle_chk: assert (csN == 5'h1F);

  // R6
  idle_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
    ((csN | LIVE) == 5'h1F));

  // R8
  idle_user_low_chk: assert property (@(posedge clk) disable iff (rst)
    ((userMode & ~LIVE) == 5'h0));

  // R7
  far_write_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (busValid && busWrite && wIdx >= REG_WORDS) |=> $stable(csN));

  // R9
  plain_write_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (busValid && busWrite && !ctrlHit) |=> $stable(csN));

  for (genvar g = 0; g < NCS; g++) begin : gFollow
    // R2
    cs_follows_bit_chk: assert property (@(posedge clk) disable iff (rst)
      (busValid && busWrite && wIdx == BASE + g) |=> (csN[g] == $past(busWdata[STOP_BIT])));
  end
endmodule

bind sflash_regbank sflash_regbank_chk #(
  .SINGLE_SLAVE(SINGLE_SLAVE), .NUM_CS(NUM_CS), .ADDR_W(ADDR_W)
) uChk (
  .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .csN(csN), .userMode(userMode)
);

// File: tb/sim_sflash_regbank.sv
module sim_sflash_regbank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] rdA, rdB;
  logic [4:0]  csA, csB, umA, umB;
  logic        weA, weB;

  int total = 0, bad = 0;
  logic [31:0] expA[$], expB[$];
  string       tagQ[$];
  logic        rdSeen = 1'b0;

  always #2.5 clk = ~clk;

  // multi-device layout, three devices
  sflash_regbank #(.SINGLE_SLAVE(1'b0), .NUM_CS(3), .ADDR_W(12)) u0 (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rdA), .csN(csA), .userMode(umA), .wrEnSlave0(weA));
  // single-device layout, four requested (clamped to one)
  sflash_regbank #(.SINGLE_SLAVE(1'b1), .NUM_CS(4), .ADDR_W(12)) u1 (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rdB), .csN(csB), .userMode(umB), .wrEnSlave0(weB));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: a read seen at a rising edge is compared at the next falling edge
  always @(posedge clk) rdSeen <= busValid && !busWrite && !rst;
  always @(negedge clk) begin
    if (rdSeen && tagQ.size() > 0) begin
      string t;
      t = tagQ.pop_front();
      check({t, " u0"}, rdA, expA.pop_front());
      check({t, " u1"}, rdB, expB.pop_front());
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] ea, logic [31:0] eb, string tag);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    expA.push_back(ea); expB.push_back(eb); tagQ.push_back(tag);
    @(negedge clk);
    busValid = 1'b0;
  endtask

  initial begin
    #(5 * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    check("R1 rdata u0", rdA, 32'h0);
    check("R1 cs u0", {27'h0, csA}, 32'h1F);
    check("R1 cs u1", {27'h0, csB}, 32'h1F);
    rd(12'h010, 32'h4, 32'h0, "R1 R4 word 0x10");
    rd(12'h004, 32'h0, 32'h4, "R1 R4 word 0x04");
    rd(12'h018, 32'h4, 32'h0, "R1 device2 ctrl");
    rd(12'h01C, 32'h0, 32'h0, "R1 R6 device3 unconfigured");
    // R2 R4 select device 0 in multi layout
    wr(12'h010, 32'h0);
    check("R2 R4 cs u0", {27'h0, csA}, 32'h1E);
    check("R9 cs u1", {27'h0, csB}, 32'h1F);
    // R4 R8 single layout control word
    wr(12'h004, 32'h3);
    check("R2 R4 cs u1", {27'h0, csB}, 32'h1E);
    check("R8 user u1", {27'h0, umB}, 32'h1);
    check("R8 R9 user/cs u0", {22'h0, umA, csA}, {22'h0, 5'h0, 5'h1E});
    // R6 unconfigured device word
    wr(12'h01C, 32'h3);
    check("R6 cs u0", {27'h0, csA}, 32'h1E);
    check("R6 R8 user u0", {27'h0, umA}, 32'h0);
    rd(12'h01C, 32'h3, 32'h3, "R3 R6 storage 0x1C");
    // R2 R8 device1 user mode and selected
    wr(12'h014, 32'h3);
    check("R2 cs u0 dev1", {27'h0, csA}, 32'h1C);
    check("R8 user u0 dev1", {27'h0, umA}, 32'h2);
    check("R9 cs u1", {27'h0, csB}, 32'h1E);
    // R5 enable bit position
    wr(12'h000, 32'h0001_0000);
    check("R5 wren 0x10000", {30'h0, weA, weB}, 32'h2);
    wr(12'h000, 32'h0000_0001);
    check("R5 wren 0x1", {30'h0, weA, weB}, 32'h1);
    // R7 out of range, would alias to word 4
    wr(12'h110, 32'hFFFF_FFFF);
    check("R7 cs", {22'h0, csA, csB}, {22'h0, 5'h1C, 5'h1E});
    rd(12'h110, 32'h0, 32'h0, "R7 far read");
    rd(12'h010, 32'h0, 32'h0, "R7 no alias");
    rd(12'hFFC, 32'h0, 32'h0, "R7 top read");
    // R2 release device 0
    wr(12'h010, 32'h0000_0004);
    check("R2 release u0", {27'h0, csA}, 32'h1D);
    // R3 R9 segment word storage
    wr(12'h030, 32'h7F7F_0000);
    check("R9 seg cs", {22'h0, csA, csB}, {22'h0, 5'h1D, 5'h1E});
    rd(12'h030, 32'h7F7F_0000, 32'h7F7F_0000, "R3 seg readback");
    rd(12'h0FC, 32'h0, 32'h0, "R3 last word");
    check("R3 rdata hold", rdA, 32'h0);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule